// File: doc/BRIEF.md
# Carry-Skip Binary Adder

This block adds two unsigned or two's-complement operands plus a carry-in and returns the sum, the carry-out and a signed overflow flag. It has no clock or state, so the results follow the operands within the same cycle. It is meant to sit inside a datapath where the carry chain of a plain ripple adder would be too long, but where a full lookahead tree would cost too much area.

The operand width is split into equal ripple-carry groups. Each group also forms a group-propagate term, which is true when every bit in the group has exactly one operand bit set. When this term is true, a mux sends the group's incoming carry straight to the next group and bypasses the group's internal ripple. The worst-case path therefore crosses one ripple group, a run of bypass muxes, and then the last group.

Width and group size are parameters. The group size must divide the width exactly, and elaboration stops if it does not. A third parameter replaces the bypass muxes with plain ripple links, which gives a reference variant of the same block.

Top module: `carry_skip_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `op_a + op_b + carry_in`, taken as unsigned integers.
- R2: `carry_out` equals bit WIDTH of `op_a + op_b + carry_in`.
- R3: `overflow` is 1 exactly when `op_a` and `op_b` have the same most significant bit and `sum` has a different one. This is the XOR of the carry entering the top bit and the carry leaving it.
- R4: If a group has `op_a` and `op_b` differing in every bit position, each sum bit of that group is the inverse of the carry that enters the group. The group's outgoing carry equals its incoming carry.
- R5: The block is combinational. All three outputs are valid in the same clock cycle in which the operands are applied, with zero registers of latency.
- R6: With `op_a` all ones, `op_b` = 1 and `carry_in` = 0, the result is `sum` = 0, `carry_out` = 1 and `overflow` = 0.
- R7: With `op_a` = 0x7FFFFFFF, `op_b` = 1 and `carry_in` = 0, the result is `sum` = 0x80000000, `carry_out` = 0 and `overflow` = 1.
- R8: With alternating operands 0xAAAAAAAA and 0x55555555, every bit propagates. `carry_in` = 1 then gives `sum` = 0 and `carry_out` = 1, and `carry_in` = 0 gives `sum` = 0xFFFFFFFF and `carry_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry leaving the top bit |
| overflow | output | 1 | Signed two's-complement overflow |

## Verification
Every result of this block is due zero cycles after its stimulus. The bench changes the operands just after a rising edge and samples `sum`, `carry_out` and `overflow` on the following falling edge of the same cycle. It never waits for a later edge, so any stray register on a result path shows up as a mismatch.

// File: rtl/csk_pkg.sv
package csk_pkg;

   // Number of ripple groups for a given width and group size.
   function automatic int unsigned grp_count(input int unsigned width,
                                             input int unsigned gsize);
      return width / gsize;
   endfunction

   // True when the group size tiles the width with nothing left over.
   function automatic bit grp_fits(input int unsigned width,
                                   input int unsigned gsize);
      return (gsize != 0) && ((width % gsize) == 0);
   endfunction

endpackage

// File: rtl/csk_pg_gen.sv
module csk_pg_gen #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] gen_o,
   output logic [WIDTH-1:0] prop_o
);

   // Per-bit generate and propagate terms.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign gen_o[i]  = a_i[i] & b_i[i];
      assign prop_o[i] = a_i[i] ^ b_i[i];
   end

endmodule

// File: rtl/csk_ripple_group.sv
module csk_ripple_group #(
   parameter int unsigned GW = 4
) (
   input  logic [GW-1:0] prop_i,
   input  logic [GW-1:0] gen_i,
   input  logic          cin_i,
   output logic [GW-1:0] sum_o,
   output logic          cout_ripple_o,
   output logic          grp_prop_o
);

   logic [GW:0] chain;

   assign chain[0] = cin_i;

   for (genvar i = 0; i < GW; i++) begin : g_stage
      assign chain[i+1] = gen_i[i] | (prop_i[i] & chain[i]);
      assign sum_o[i]   = prop_i[i] ^ chain[i];
   end

   assign cout_ripple_o = chain[GW];
   assign grp_prop_o    = &prop_i;

   // When every bit propagates, the ripple chain must agree with the bypass.
   always_comb begin
      if (!$isunknown({prop_i, gen_i, cin_i}) && grp_prop_o) begin
         a_r4_bypass_agrees: assert (cout_ripple_o == cin_i)
            else $error("R4: ripple carry %b differs from group carry-in %b",
                        cout_ripple_o, cin_i);
         a_r4_sum_inverts: assert (sum_o == {GW{~cin_i}})
            else $error("R4: group sum %h is not the inverted carry-in", sum_o);
      end
   end

endmodule

// File: rtl/csk_skip_mux.sv
module csk_skip_mux #(
   parameter bit SKIP_EN = 1'b1
) (
   input  logic skip_i,
   input  logic cin_i,
   input  logic ripple_i,
   output logic cout_o
);

   if (SKIP_EN) begin : g_skip
      assign cout_o = skip_i ? cin_i : ripple_i;
   end else begin : g_plain
      logic unused_ok;
      assign unused_ok = skip_i ^ cin_i;
      assign cout_o    = ripple_i | (unused_ok & 1'b0);
   end

endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder #(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned GROUP   = 4,
   parameter bit          SKIP_EN = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out,
   output logic             overflow
);

   import csk_pkg::*;

   localparam int unsigned NGRP = grp_count(WIDTH, GROUP);
   localparam int unsigned MSB  = WIDTH - 1;

   // Elaboration-time parameter checks.
   if (WIDTH < 2) begin : g_bad_width
      $error("carry_skip_adder: WIDTH must be at least 2");
   end
   if (!grp_fits(WIDTH, GROUP)) begin : g_bad_group
      $error("carry_skip_adder: GROUP must be nonzero and divide WIDTH");
   end

   logic [WIDTH-1:0] gen_w;
   logic [WIDTH-1:0] prop_w;
   logic [NGRP:0]    grp_carry;
   logic             msb_carry_in;

   csk_pg_gen #(.WIDTH(WIDTH)) pg_i (
      .a_i    (op_a),
      .b_i    (op_b),
      .gen_o  (gen_w),
      .prop_o (prop_w)
   );

   assign grp_carry[0] = carry_in;

   for (genvar k = 0; k < NGRP; k++) begin : g_grp
      logic ripple_c;
      logic skip_c;

      csk_ripple_group #(.GW(GROUP)) rg_i (
         .prop_i        (prop_w[k*GROUP +: GROUP]),
         .gen_i         (gen_w[k*GROUP +: GROUP]),
         .cin_i         (grp_carry[k]),
         .sum_o         (sum[k*GROUP +: GROUP]),
         .cout_ripple_o (ripple_c),
         .grp_prop_o    (skip_c)
      );

      csk_skip_mux #(.SKIP_EN(SKIP_EN)) mx_i (
         .skip_i   (skip_c),
         .cin_i    (grp_carry[k]),
         .ripple_i (ripple_c),
         .cout_o   (grp_carry[k+1])
      );
   end

   assign carry_out = grp_carry[NGRP];

   // The carry entering the top bit is recovered from its sum and propagate.
   assign msb_carry_in = prop_w[MSB] ^ sum[MSB];
   assign overflow     = msb_carry_in ^ carry_out;

   always_comb begin
      if (!$isunknown({op_a, op_b, carry_in})) begin
         a_r1_r2_sum_exact: assert ({carry_out, sum} ==
                                    ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
            else $error("R1/R2: adder result mismatch");
         a_r3_overflow_sign: assert (overflow ==
                                     ((op_a[MSB] == op_b[MSB]) && (sum[MSB] != op_a[MSB])))
            else $error("R3: overflow flag inconsistent with operand signs");
      end
   end

endmodule

// File: tb/carry_skip_adder_tb.sv
`timescale 1ns/1ps
module carry_skip_adder_tb_top;

   localparam int unsigned W = 32;
   localparam int unsigned G = 4;

   logic         clk = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] sum;
   logic         carry_out;
   logic         overflow;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   carry_skip_adder #(.WIDTH(W), .GROUP(G)) dut_i (
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .sum       (sum),
      .carry_out (carry_out),
      .overflow  (overflow)
   );

   function automatic logic [W:0] ref_add(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic c);
      return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
   endfunction

   function automatic logic ref_ovf(input logic [W-1:0] a,
                                    input logic [W-1:0] b,
                                    input logic [W-1:0] s);
      return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
   endfunction

   task automatic check(input string req, input logic [W+1:0] act,
                        input logic [W+1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive just after a rising edge; sample at the falling edge of the same cycle (R5).
   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic c, input string req);
      logic [W:0] r;
      @(posedge clk);
      #1;
      op_a = a; op_b = b; carry_in = c;
      @(negedge clk);
      r = ref_add(a, b, c);
      check({req, " R5 R1 R2 R3"}, {carry_out, overflow, sum},
            {r[W], ref_ovf(a, b, r[W-1:0]), r[W-1:0]});
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL R5 watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1357_2468));

      // Initial all-zero inputs, zero latency (R5)
      @(negedge clk);
      check("R5 zero inputs", {carry_out, overflow, sum}, '0);

      apply(32'hFFFF_FFFF, 32'h1, 1'b0, "R6");
      check("R6 exact", {carry_out, overflow, sum}, {1'b1, 1'b0, 32'h0});

      apply(32'h7FFF_FFFF, 32'h1, 1'b0, "R7");
      check("R7 exact", {carry_out, overflow, sum}, {1'b0, 1'b1, 32'h8000_0000});

      apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R8 cin1");
      check("R8 cin1 exact", {carry_out, overflow, sum}, {1'b1, 1'b0, 32'h0});
      apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R8 cin0");
      check("R8 cin0 exact", {carry_out, overflow, sum}, {1'b0, 1'b0, 32'hFFFF_FFFF});

      apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 neg+neg");
      apply(32'h5555_5555, 32'h5555_5555, 1'b1, "R1 alt same");
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2 max");
      apply(32'h0, 32'h0, 1'b1, "R1 cin only");

      // Random operands with one group forced to full propagate (R4)
      for (int n = 0; n < 1500; n++) begin
         logic [W-1:0] a, b, m;
         logic         c;
         logic [W:0]   r;
         logic         gcin;
         int unsigned  k;
         a = $urandom();
         b = $urandom();
         c = 1'($urandom());
         case (n % 4)
            0: b = a;
            1: b = ~a;
            default: ;
         endcase
         k = $urandom_range(W / G - 1);
         m = {{(W-G){1'b0}}, {G{1'b1}}} << (k * G);
         b = (b & ~m) | (~a & m);
         apply(a, b, c, "R1 random");
         r    = ref_add(a & ((m - 1)), b & ((m - 1)), c);
         gcin = (k == 0) ? c : r[k*G];
         check("R4 group bypass", {2'b00, (sum & m)},
               {2'b00, ({W{~gcin}} & m)});
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule